// File: doc/BRIEF.md
# Lane-wise doubleword shuffle unit

This block is a registered permute datapath for vectors of up to 512 bits. It treats the vector as 128-bit lanes of four 32-bit elements. An 8-bit order control picks, for each destination element position, which element of the same source lane is copied there. Every lane uses the same order control, and no data crosses a lane boundary. A source element may be copied to several positions.

Several controls shape the result. A broadcast input replaces every source element with one 32-bit scalar before the shuffle. The active length can be 128, 256 or 512 bits. An extended mode turns on optional per-element masking, where each masked-off element either keeps its old destination value or is cleared. The extended mode also clears every bit above the active length. A legacy mode always works on 128 bits and passes the old upper destination bits through unchanged.

Each request is sampled on a cycle with `in_valid_i` high. The result appears on `dst_o` one clock later, with `out_valid_o` high for that single cycle.

Top module: `vshuf_unit`

## Requirements
- R1: Destination element k of a lane (k = 0..3, element k occupying bits 32k+31:32k of the lane) takes the source element of the same lane whose index is order_i[2k+1:2k].
- R2: Each 128-bit lane is shuffled only from the matching source lane, and all lanes use the same order_i value.
- R3: Two or more destination elements may select the same source element, and each gets a full copy of it.
- R4: With bcast_i high, every source element is replaced by scalar_i before the shuffle, so every selected element equals scalar_i.
- R5: In extended mode with mask_en_i high, an active element whose bit in mask_i is set (bit e belongs to element e, counted from the least significant end) takes the shuffled value. If its bit is clear and zero_mode_i is low, it takes the matching element of old_dst_i.
- R6: In extended mode with mask_en_i high, an active element whose mask bit is clear is zero when zero_mode_i is high.
- R7: In extended mode, vlen_i selects the active length: 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. All result bits above the active length are zero, and mask bits above it have no effect.
- R8: In legacy mode (ext_mode_i low), the active length is 128 bits whatever vlen_i holds, and mask_en_i, mask_i and zero_mode_i have no effect. Result bits 511:128 equal the matching bits of old_dst_i.
- R9: With mask_en_i low, every active element takes its shuffled value, whatever mask_i and zero_mode_i hold.
- R10: A request sampled with in_valid_i high puts its result on dst_o at the next rising clock edge, and out_valid_o is high for exactly that cycle. Without in_valid_i, out_valid_o falls and dst_o holds its value.
- R11: While rst_ni is low, dst_o and out_valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| src_i | input | 512 | Source vector |
| scalar_i | input | 32 | Broadcast scalar |
| bcast_i | input | 1 | Replace every source element with scalar_i |
| order_i | input | 8 | Four 2-bit element selectors |
| vlen_i | input | 2 | Active length code: 0=128, 1=256, 2/3=512 |
| ext_mode_i | input | 1 | 1 = extended mode, 0 = legacy mode |
| mask_en_i | input | 1 | Enable per-element masking (extended mode) |
| mask_i | input | 16 | Per-element mask bits |
| zero_mode_i | input | 1 | 1 = clear masked-off elements, 0 = keep old value |
| old_dst_i | input | 512 | Current destination value |
| out_valid_o | output | 1 | Result valid |
| dst_o | output | 512 | Registered result vector |

## Verification
The bench uses orders that reverse the elements, rotate them and duplicate one element, so a design that swapped selector fields or drew data from a neighbouring lane would put the wrong elements in place. It applies irregular mask patterns in both merge and zero mode, so inverting the zero select or misnumbering mask bits would show up as mismatched elements. It covers 128-bit and 256-bit lengths with mask bits set above the active length, and a legacy request that carries a 512-bit length and an all-clear mask; a design that zeroed the legacy upper bits or obeyed the mask in legacy mode would fail there. Back-to-back requests, idle cycles and a reset in the middle of a run catch a result that arrives a cycle late, is not held, or survives reset.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
  localparam int DEF_ELEM_W     = 32;
  localparam int DEF_LANE_ELEMS = 4;
  localparam int DEF_NUM_LANES  = 4;
  localparam int VLEN_W         = 2;

  typedef enum logic [VLEN_W-1:0] {
    VLEN_L1  = 2'd0,
    VLEN_L2  = 2'd1,
    VLEN_L4  = 2'd2,
    VLEN_L4B = 2'd3
  } vlen_e;
endpackage

// File: rtl/vshuf_bcast.sv
module vshuf_bcast #(
  parameter int ELEM_W    = 32,
  parameter int NUM_ELEMS = 16
) (
  input  logic [ELEM_W*NUM_ELEMS-1:0] src_i,
  input  logic [ELEM_W-1:0]           scalar_i,
  input  logic                        bcast_i,
  output logic [ELEM_W*NUM_ELEMS-1:0] src_o
);
  for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_elem
    assign src_o[e*ELEM_W +: ELEM_W] = bcast_i ? scalar_i : src_i[e*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/vshuf_lane.sv
module vshuf_lane #(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  localparam int SEL_W     = $clog2(LANE_ELEMS),
  localparam int LANE_W    = ELEM_W * LANE_ELEMS,
  localparam int ORDER_W   = SEL_W * LANE_ELEMS
) (
  input  logic [LANE_W-1:0]  lane_src_i,
  input  logic [ORDER_W-1:0] order_i,
  output logic [LANE_W-1:0]  lane_dst_o
);
  logic [ELEM_W-1:0] elems [LANE_ELEMS];

  for (genvar k = 0; k < LANE_ELEMS; k++) begin : g_unpack
    assign elems[k] = lane_src_i[k*ELEM_W +: ELEM_W];
  end

  // same selector field drives position k in every lane instance
  for (genvar k = 0; k < LANE_ELEMS; k++) begin : g_pick
    logic [SEL_W-1:0] sel;
    assign sel = order_i[k*SEL_W +: SEL_W];
    assign lane_dst_o[k*ELEM_W +: ELEM_W] = elems[sel];
  end
endmodule

// File: rtl/vshuf_ctrl.sv
module vshuf_ctrl import vshuf_pkg::*; #(
  parameter int LANE_ELEMS = 4,
  parameter int NUM_LANES  = 4,
  localparam int NUM_ELEMS = LANE_ELEMS * NUM_LANES,
  localparam int CNT_W     = $clog2(NUM_LANES) + 3
) (
  input  logic [VLEN_W-1:0]    vlen_i,
  input  logic                 ext_mode_i,
  input  logic                 mask_en_i,
  input  logic [NUM_ELEMS-1:0] mask_i,
  output logic [NUM_LANES-1:0] lane_act_o,
  output logic [NUM_ELEMS-1:0] mask_eff_o,
  output logic                 tail_zero_o
);
  logic [CNT_W-1:0] act_cnt;
  vlen_e            vlen;

  assign vlen = vlen_e'(vlen_i);

  always_comb begin
    if (!ext_mode_i) act_cnt = CNT_W'(1);
    else             act_cnt = CNT_W'(1) << vlen;
    if (act_cnt > CNT_W'(NUM_LANES)) act_cnt = CNT_W'(NUM_LANES);
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_act
    assign lane_act_o[l] = CNT_W'(l) < act_cnt;
  end

  assign mask_eff_o  = (ext_mode_i && mask_en_i) ? mask_i : '1;
  assign tail_zero_o = ext_mode_i;
endmodule

// File: rtl/vshuf_merge.sv
module vshuf_merge #(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  parameter int NUM_LANES  = 4,
  localparam int NUM_ELEMS = LANE_ELEMS * NUM_LANES,
  localparam int VEC_W     = ELEM_W * NUM_ELEMS
) (
  input  logic [VEC_W-1:0]     shuf_i,
  input  logic [VEC_W-1:0]     old_i,
  input  logic [NUM_LANES-1:0] lane_act_i,
  input  logic [NUM_ELEMS-1:0] mask_eff_i,
  input  logic                 zero_mode_i,
  input  logic                 tail_zero_i,
  output logic [VEC_W-1:0]     result_o
);
  for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_elem
    localparam int LN = e / LANE_ELEMS;
    logic [ELEM_W-1:0] shuf_e, old_e, res_e;
    assign shuf_e = shuf_i[e*ELEM_W +: ELEM_W];
    assign old_e  = old_i[e*ELEM_W +: ELEM_W];
    always_comb begin
      if (lane_act_i[LN]) begin
        if (mask_eff_i[e])    res_e = shuf_e;
        else if (zero_mode_i) res_e = '0;
        else                  res_e = old_e;
      end else begin
        res_e = tail_zero_i ? '0 : old_e;
      end
    end
    assign result_o[e*ELEM_W +: ELEM_W] = res_e;
  end
endmodule

// File: rtl/vshuf_unit.sv
module vshuf_unit import vshuf_pkg::*; #(
  parameter int ELEM_W     = DEF_ELEM_W,
  parameter int LANE_ELEMS = DEF_LANE_ELEMS,
  parameter int NUM_LANES  = DEF_NUM_LANES,
  localparam int SEL_W     = $clog2(LANE_ELEMS),
  localparam int ORDER_W   = SEL_W * LANE_ELEMS,
  localparam int LANE_W    = ELEM_W * LANE_ELEMS,
  localparam int NUM_ELEMS = LANE_ELEMS * NUM_LANES,
  localparam int VEC_W     = ELEM_W * NUM_ELEMS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [VEC_W-1:0]     src_i,
  input  logic [ELEM_W-1:0]    scalar_i,
  input  logic                 bcast_i,
  input  logic [ORDER_W-1:0]   order_i,
  input  logic [VLEN_W-1:0]    vlen_i,
  input  logic                 ext_mode_i,
  input  logic                 mask_en_i,
  input  logic [NUM_ELEMS-1:0] mask_i,
  input  logic                 zero_mode_i,
  input  logic [VEC_W-1:0]     old_dst_i,
  output logic                 out_valid_o,
  output logic [VEC_W-1:0]     dst_o
);
  logic [VEC_W-1:0]     src_prep, shuf, result;
  logic [NUM_LANES-1:0] lane_act;
  logic [NUM_ELEMS-1:0] mask_eff;
  logic                 tail_zero;

  vshuf_bcast #(.ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS)) u_bcast (
    .src_i(src_i), .scalar_i(scalar_i), .bcast_i(bcast_i), .src_o(src_prep)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    vshuf_lane #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS)) u_lane (
      .lane_src_i(src_prep[l*LANE_W +: LANE_W]),
      .order_i   (order_i),
      .lane_dst_o(shuf[l*LANE_W +: LANE_W])
    );
  end

  vshuf_ctrl #(.LANE_ELEMS(LANE_ELEMS), .NUM_LANES(NUM_LANES)) u_ctrl (
    .vlen_i(vlen_i), .ext_mode_i(ext_mode_i), .mask_en_i(mask_en_i), .mask_i(mask_i),
    .lane_act_o(lane_act), .mask_eff_o(mask_eff), .tail_zero_o(tail_zero)
  );

  vshuf_merge #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS), .NUM_LANES(NUM_LANES)) u_merge (
    .shuf_i(shuf), .old_i(old_dst_i), .lane_act_i(lane_act), .mask_eff_i(mask_eff),
    .zero_mode_i(zero_mode_i), .tail_zero_i(tail_zero), .result_o(result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dst_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) dst_o <= result;
    end
  end

  assert_valid_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_valid_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(dst_o));
  assert_legacy_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !ext_mode_i) |=> dst_o[VEC_W-1:LANE_W] == $past(old_dst_i[VEC_W-1:LANE_W]));
  assert_tail_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ext_mode_i && vlen_i == VLEN_L1) |=> dst_o[VEC_W-1:LANE_W] == '0);
  assert_zero_elem_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ext_mode_i && mask_en_i && zero_mode_i && !mask_i[0]) |=> dst_o[ELEM_W-1:0] == '0);
  assert_bcast_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && bcast_i && !(ext_mode_i && mask_en_i)) |=> dst_o[ELEM_W-1:0] == $past(scalar_i));
endmodule

// File: tb/vshuf_unit_bench.sv
module vshuf_unit_bench;
  typedef struct packed {
    logic [7:0]  order;
    logic [1:0]  vlen;
    logic        ext;
    logic        bcast;
    logic        men;
    logic [15:0] mask;
    logic        zero;
    logic [3:0]  seed;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'hE4, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 4'h1}, // identity
    '{8'h1B, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 4'h2}, // reverse
    '{8'h00, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 4'h3}, // dup elem 0
    '{8'hFF, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 4'h4}, // dup elem 3
    '{8'h4E, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 4'h5}, // broadcast
    '{8'h39, 2'd2, 1'b1, 1'b0, 1'b1, 16'hA5C3, 1'b0, 4'h6}, // merge
    '{8'h93, 2'd2, 1'b1, 1'b0, 1'b1, 16'h0F0F, 1'b1, 4'h7}, // zero
    '{8'hD8, 2'd1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 4'h8}, // 256 ext
    '{8'h1B, 2'd0, 1'b1, 1'b0, 1'b1, 16'hFFFF, 1'b1, 4'h9}, // 128 ext, upper mask ignored
    '{8'h1B, 2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 4'hA}, // legacy, mask ignored
    '{8'h72, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 4'hB}, // mask disabled
    '{8'hB1, 2'd1, 1'b1, 1'b0, 1'b1, 16'hFFF0, 1'b0, 4'hC}, // 256 merge
    '{8'h2D, 2'd3, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 4'hD}, // code 3 = 512
    '{8'h00, 2'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'hE}  // legacy broadcast
  };

  function automatic string tag_of(input int i);
    case (i)
      0:  return "R1";
      1:  return "R2";
      2:  return "R3";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R7";
      9:  return "R8";
      10: return "R9";
      11: return "R5";
      12: return "R7";
      default: return "R8";
    endcase
  endfunction

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0, old = '0;
  logic [31:0]  scalar = '0;
  logic         bcast = 1'b0, ext = 1'b0, men = 1'b0, zero = 1'b0;
  logic [7:0]   order = '0;
  logic [1:0]   vlen = '0;
  logic [15:0]  mask = '0;
  logic         out_valid;
  logic [511:0] dst;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vshuf_unit u_vshuf_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .src_i(src), .scalar_i(scalar),
    .bcast_i(bcast), .order_i(order), .vlen_i(vlen), .ext_mode_i(ext), .mask_en_i(men),
    .mask_i(mask), .zero_mode_i(zero), .old_dst_i(old), .out_valid_o(out_valid), .dst_o(dst)
  );

  function automatic logic [511:0] mk_src(input logic [3:0] seed);
    logic [511:0] r;
    for (int j = 0; j < 16; j++) r[j*32 +: 32] = 32'hA000_0000 | (32'(seed) << 16) | 32'(j);
    return r;
  endfunction

  function automatic logic [511:0] mk_old(input logic [3:0] seed);
    logic [511:0] r;
    for (int j = 0; j < 16; j++) r[j*32 +: 32] = 32'hD000_0000 | (32'(seed) << 12) | 32'(j + 16);
    return r;
  endfunction

  function automatic logic [511:0] model(input vec_t v, input logic [511:0] s, input logic [511:0] o,
                                         input logic [31:0] sc);
    logic [511:0] r;
    int lanes;
    r = '0;
    if (!v.ext) lanes = 1;
    else if (v.vlen == 2'd0) lanes = 1;
    else if (v.vlen == 2'd1) lanes = 2;
    else lanes = 4;
    for (int e = 0; e < 16; e++) begin
      int ln;
      int k;
      int pick;
      logic [31:0] sv, ov;
      ln   = e / 4;
      k    = e % 4;
      pick = int'(v.order[2*k +: 2]);
      ov   = o[e*32 +: 32];
      sv   = v.bcast ? sc : s[(ln*4 + pick)*32 +: 32];
      if (ln < lanes) begin
        if (v.ext && v.men && !v.mask[e]) r[e*32 +: 32] = v.zero ? 32'h0 : ov;
        else                              r[e*32 +: 32] = sv;
      end else begin
        r[e*32 +: 32] = v.ext ? 32'h0 : ov;
      end
    end
    return r;
  endfunction

  task automatic chk_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dst actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s out_valid actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge, returns expected result
  task automatic drive(input int i, output logic [511:0] exp);
    vec_t v;
    v = VECS[i];
    @(negedge clk);
    src = mk_src(v.seed); old = mk_old(v.seed);
    scalar = 32'h5CA1_0000 | 32'(v.seed);
    order = v.order; vlen = v.vlen; ext = v.ext; bcast = v.bcast;
    men = v.men; mask = v.mask; zero = v.zero;
    in_valid = 1'b1;
    exp = model(v, src, old, scalar);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] exp_a, exp_b, held;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk_vec("R11", dst, '0);
    chk_bit("R11", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(i, exp_a);
      @(negedge clk);
      in_valid = 1'b0;
      chk_vec(tag_of(i), dst, exp_a);
      chk_bit("R10", out_valid, 1'b1);
      held = dst;
      // R10: idle cycle, inputs change, output held
      src = ~src; old = ~old;
      @(negedge clk);
      chk_bit("R10", out_valid, 1'b0);
      chk_vec("R10", dst, held);
    end

    // R10: back-to-back requests
    drive(1, exp_a);
    drive(6, exp_b);
    chk_vec("R10", dst, exp_a);
    chk_bit("R10", out_valid, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R10", dst, exp_b);
    chk_bit("R10", out_valid, 1'b1);

    // R11: reset mid-run clears output
    drive(4, exp_a);
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R4", dst, exp_a);
    rst_n = 1'b0;
    #2;
    chk_vec("R11", dst, '0);
    chk_bit("R11", out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule